// File: doc/BRIEF.md
# Bit-Plane Arithmetic-Coder Engine Allocator

This block connects one bit-plane context modeller to two arithmetic-coding engines. Each engine holds one lane per coding pass: significance, refinement and cleanup. Each lane has a 16-entry buffer of context/decision pairs and a read controller. The read controller hands buffered pairs to that lane's arithmetic encoder and starts it while data is waiting. The encoders sit outside this block. The significance and cleanup encoders can take two pairs in one cycle. The refinement encoder takes only one.

The modeller streams pairs for the current bit plane through three ready/valid pass inputs, and the allocator steers them into the engine that owns that plane. When a plane scan is finished, the modeller holds a plane request. Bit planes go to the engines in turn, so the request targets the other engine. The allocator grants the request in the same cycle, but only if the target engine has drained: its three buffers are empty and its three encoders report idle. If the target has not drained, the modeller stalls until it has. The engine that is not receiving keeps draining, so modelling and arithmetic coding run at the same time.

The controller has three states. IDLE holds no grant and is the state after reset. CODE holds a grant, and pairs are accepted in it. STALL means a request is pending for an engine that is still busy. The transitions are:
- IDLE or CODE, with a request and a free target, goes to CODE and issues a grant.
- IDLE or CODE, with a request and a busy target, goes to STALL.
- STALL, once the target is free, goes to CODE and issues a grant.

Top module: `bp_mq_alloc`

## Requirements
- R1: After reset, `pass_ready`, `plane_gnt`, `alloc_stall`, `enc_run`, `enc_two` and `act_eng` are all zero.
- R2: `pass_ready` is low for every pass when no grant is held (IDLE or STALL) and in any cycle where `plane_req` is high.
- R3: While a grant is held and no request is pending, `pass_ready[p]` is high exactly when the lane for pass p of the granted engine holds fewer than 16 pairs; a buffer never exceeds 16 pairs.
- R4: A pair accepted on pass p (0 significance, 1 refinement, 2 cleanup) enters lane `act_eng*3+p`, and each lane delivers its pairs in arrival order. A pair is packed as {cx[4:0], d}.
- R5: The first grant after reset assigns engine 0, and each later grant assigns the other engine. `act_eng` shows the engine of the latest grant from the cycle after the handshake.
- R6: `plane_gnt` is high exactly when `plane_req` is high and the target engine's three lanes are empty and its three `enc_busy` bits are low. The request is served when `plane_req` and `plane_gnt` are both high at a clock edge.
- R7: `alloc_stall` is high in every cycle that follows a clock edge at which `plane_req` was high and `plane_gnt` was low, until a grant is issued.
- R8: `enc_run[l]` is high exactly when lane l holds at least one pair, and `enc_cx0`/`enc_d0` then present the oldest pair.
- R9: On the significance and cleanup lanes, `enc_two` is high when two or more pairs are held, and `enc_cx1`/`enc_d1` then present the second-oldest pair. On the refinement lanes, `enc_two` stays low.
- R10: The two-bit `enc_take` field of a lane asks for 0, 1 or 2 pairs (code 3 means 2). The lane removes the smaller of that number and the pairs it currently offers, so a take on an empty lane has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pass_valid | input | 3 | Per-pass pair valid (0 sig, 1 ref, 2 cleanup) |
| pass_cx | input | 15 | Per-pass 5-bit context, pass p at bits 5p+4:5p |
| pass_d | input | 3 | Per-pass decision bit |
| pass_ready | output | 3 | Per-pass ready |
| plane_req | input | 1 | Level request for an engine for the next plane |
| plane_gnt | output | 1 | Grant; handshake when high with plane_req |
| act_eng | output | 1 | Engine that owns the current plane |
| alloc_stall | output | 1 | Request pending on a busy engine |
| enc_run | output | 6 | Lane has data; encoder start/stop |
| enc_two | output | 6 | Second pair offered (dual lanes only) |
| enc_cx0 | output | 30 | Oldest context per lane, lane l at 5l+4:5l |
| enc_d0 | output | 6 | Oldest decision per lane |
| enc_cx1 | output | 30 | Second-oldest context per lane |
| enc_d1 | output | 6 | Second-oldest decision per lane |
| enc_take | input | 12 | Per-lane consume count, lane l at bits 2l+1:2l |
| enc_busy | input | 6 | Per-lane encoder still working |

## Verification
A wrong plane-to-engine mapping shows up in the cycle after the handshake. The pairs then land on the wrong lane's `enc_run`/`enc_cx0`, and `act_eng` differs from the alternation. A wrong buffer count shows up as soon as the buffer fills or drains: `pass_ready` or `enc_two` flips one pair early or late, or a stale head pair appears. A wrong free test shows up in the very cycle the request is raised, because `plane_gnt` is a same-cycle function of lane occupancy and encoder busy. Any error in the STALL state shows in `alloc_stall` one edge later.

// File: rtl/bpa_pkg.sv
package bpa_pkg;
    localparam int CX_W     = 5;
    localparam int NUM_PASS = 3;
    localparam int NUM_ENG  = 2;
    localparam int ENG_W    = (NUM_ENG > 1) ? $clog2(NUM_ENG) : 1;
    localparam int NLANE    = NUM_ENG * NUM_PASS;
    localparam int PASS_SIG = 0;
    localparam int PASS_REF = 1;
    localparam int PASS_CLN = 2;

    typedef struct packed {
        logic [CX_W-1:0] cx;
        logic            d;
    } cxd_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CODE  = 2'd1,
        ST_STALL = 2'd2
    } alloc_st_e;
endpackage

// File: rtl/bpa_fifo.sv
module bpa_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               wdata,
    input  logic [1:0]                 pop_n,
    output logic [W-1:0]               head0,
    output logic [W-1:0]               head1,
    output logic [$clog2(DEPTH):0]     cnt
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) begin
                wr_ptr <= wr_ptr + AW'(1);
            end
            rd_ptr <= rd_ptr + AW'(pop_n);
            cnt    <= cnt + CW'(push) - CW'(pop_n);
        end
    end

    assign head0 = mem[rd_ptr];
    assign head1 = mem[rd_ptr + AW'(1)];
endmodule

// File: rtl/bpa_rd_ctrl.sv
module bpa_rd_ctrl import bpa_pkg::*; #(
    parameter bit DUAL = 1'b1,
    parameter int CW   = 5
) (
    input  logic [CW-1:0] cnt,
    input  cxd_t          head0,
    input  cxd_t          head1,
    input  logic [1:0]    take,
    output logic          run,
    output logic          two,
    output cxd_t          out0,
    output cxd_t          out1,
    output logic [1:0]    pop_n
);
    logic [1:0] avail;
    logic [1:0] want;

    always_comb begin
        if (cnt == '0) begin
            avail = 2'd0;
        end else if (DUAL && cnt >= CW'(2)) begin
            avail = 2'd2;
        end else begin
            avail = 2'd1;
        end
        want  = take[1] ? 2'd2 : take;
        pop_n = (want > avail) ? avail : want;
        run   = (avail != 2'd0);
        two   = (avail == 2'd2);
        out0  = run ? head0 : '0;
        out1  = two ? head1 : '0;
    end
endmodule

// File: rtl/bpa_fsm.sv
module bpa_fsm import bpa_pkg::*; (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               plane_req,
    input  logic [NUM_ENG-1:0] eng_free,
    output logic               plane_gnt,
    output logic               coding,
    output logic               stall,
    output logic [ENG_W-1:0]   cur_eng
);
    alloc_st_e          st_q;
    alloc_st_e          st_nx;
    logic [ENG_W-1:0]   nxt_eng;
    logic               tgt_free;

    assign tgt_free = eng_free[nxt_eng];

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_IDLE, ST_CODE: begin
                if (plane_req) begin
                    st_nx = tgt_free ? ST_CODE : ST_STALL;
                end
            end
            ST_STALL: begin
                if (plane_req && tgt_free) begin
                    st_nx = ST_CODE;
                end
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_eng <= '0;
            nxt_eng <= '0;
        end else if (plane_gnt) begin
            cur_eng <= nxt_eng;
            nxt_eng <= (nxt_eng == ENG_W'(NUM_ENG - 1)) ? '0 : nxt_eng + ENG_W'(1);
        end
    end

    always_comb begin
        plane_gnt = plane_req && tgt_free;
        coding    = 1'b0;
        stall     = 1'b0;
        unique case (st_q)
            ST_IDLE:  ;
            ST_CODE:  coding = 1'b1;
            ST_STALL: stall  = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/bp_mq_alloc.sv
module bp_mq_alloc import bpa_pkg::*; #(
    parameter int DEPTH = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_PASS-1:0]       pass_valid,
    input  logic [NUM_PASS*CX_W-1:0]  pass_cx,
    input  logic [NUM_PASS-1:0]       pass_d,
    output logic [NUM_PASS-1:0]       pass_ready,
    input  logic                      plane_req,
    output logic                      plane_gnt,
    output logic [ENG_W-1:0]          act_eng,
    output logic                      alloc_stall,
    output logic [NLANE-1:0]          enc_run,
    output logic [NLANE-1:0]          enc_two,
    output logic [NLANE*CX_W-1:0]     enc_cx0,
    output logic [NLANE-1:0]          enc_d0,
    output logic [NLANE*CX_W-1:0]     enc_cx1,
    output logic [NLANE-1:0]          enc_d1,
    input  logic [2*NLANE-1:0]        enc_take,
    input  logic [NLANE-1:0]          enc_busy
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic [NLANE*CW-1:0] lane_cnt;
    logic [NLANE-1:0]    lane_full;
    logic [NUM_ENG-1:0]  eng_free;
    logic                coding;

    bpa_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .plane_req (plane_req),
        .eng_free  (eng_free),
        .plane_gnt (plane_gnt),
        .coding    (coding),
        .stall     (alloc_stall),
        .cur_eng   (act_eng)
    );

    always_comb begin
        for (int e = 0; e < NUM_ENG; e++) begin
            eng_free[e] = 1'b1;
            for (int p = 0; p < NUM_PASS; p++) begin
                if (lane_cnt[(e*NUM_PASS+p)*CW +: CW] != '0 || enc_busy[e*NUM_PASS+p]) begin
                    eng_free[e] = 1'b0;
                end
            end
        end
    end

    always_comb begin
        for (int p = 0; p < NUM_PASS; p++) begin
            pass_ready[p] = coding && !plane_req
                            && !lane_full[int'(act_eng)*NUM_PASS + p];
        end
    end

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        localparam int P = l % NUM_PASS;
        localparam int E = l / NUM_PASS;

        logic       push;
        cxd_t       wdata;
        cxd_t       head0;
        cxd_t       head1;
        cxd_t       out0;
        cxd_t       out1;
        logic [1:0] pop_n;
        logic [CW-1:0] cnt;

        assign push     = pass_valid[P] && pass_ready[P] && (act_eng == ENG_W'(E));
        assign wdata    = '{cx: pass_cx[P*CX_W +: CX_W], d: pass_d[P]};
        assign lane_cnt[l*CW +: CW] = cnt;
        assign lane_full[l] = (cnt == CW'(DEPTH));

        bpa_fifo #(.DEPTH(DEPTH), .W($bits(cxd_t))) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (push),
            .wdata (wdata),
            .pop_n (pop_n),
            .head0 (head0),
            .head1 (head1),
            .cnt   (cnt)
        );

        bpa_rd_ctrl #(.DUAL(P != PASS_REF), .CW(CW)) u_ctrl (
            .cnt   (cnt),
            .head0 (head0),
            .head1 (head1),
            .take  (enc_take[2*l +: 2]),
            .run   (enc_run[l]),
            .two   (enc_two[l]),
            .out0  (out0),
            .out1  (out1),
            .pop_n (pop_n)
        );

        assign enc_cx0[l*CX_W +: CX_W] = out0.cx;
        assign enc_d0[l]               = out0.d;
        assign enc_cx1[l*CX_W +: CX_W] = out1.cx;
        assign enc_d1[l]               = out1.d;
    end
endmodule

// File: rtl/bp_mq_alloc_chk.sv
module bp_mq_alloc_chk import bpa_pkg::*; #(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH) + 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  plane_req,
    input logic                  plane_gnt,
    input logic [ENG_W-1:0]      act_eng,
    input logic                  alloc_stall,
    input logic [NUM_PASS-1:0]   pass_ready,
    input logic [NLANE-1:0]      enc_busy,
    input logic [NLANE*CW-1:0]   lane_cnt
);
    logic [ENG_W-1:0] tgt;
    logic             tgt_free;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt <= '0;
        end else if (plane_req && plane_gnt) begin
            tgt <= (tgt == ENG_W'(NUM_ENG - 1)) ? '0 : tgt + ENG_W'(1);
        end
    end

    always_comb begin
        tgt_free = 1'b1;
        for (int p = 0; p < NUM_PASS; p++) begin
            if (lane_cnt[(int'(tgt)*NUM_PASS+p)*CW +: CW] != '0
                || enc_busy[int'(tgt)*NUM_PASS+p]) begin
                tgt_free = 1'b0;
            end
        end
    end

    for (genvar l = 0; l < NLANE; l++) begin : g_ov
        p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
            lane_cnt[l*CW +: CW] <= CW'(DEPTH));
    end

    p_grant_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
        plane_gnt |-> (plane_req && tgt_free));

    p_alternate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (plane_req && plane_gnt) |=> (act_eng == $past(tgt)));

    p_stall_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (plane_req && !plane_gnt) |=> alloc_stall);

    p_stall_no_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_stall |-> (pass_ready == '0));

    p_req_no_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        plane_req |-> (pass_ready == '0));
endmodule

bind bp_mq_alloc bp_mq_alloc_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .plane_req   (plane_req),
    .plane_gnt   (plane_gnt),
    .act_eng     (act_eng),
    .alloc_stall (alloc_stall),
    .pass_ready  (pass_ready),
    .enc_busy    (enc_busy),
    .lane_cnt    (lane_cnt)
);

// File: tb/bp_mq_alloc_bench.sv
module bp_mq_alloc_bench;
    localparam int DEPTH = 16;
    localparam int NL = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  pass_valid = '0;
    logic [14:0] pass_cx = '0;
    logic [2:0]  pass_d = '0;
    logic [2:0]  pass_ready;
    logic        plane_req = 1'b0;
    logic        plane_gnt;
    logic [0:0]  act_eng;
    logic        alloc_stall;
    logic [5:0]  enc_run, enc_two, enc_d0, enc_d1;
    logic [29:0] enc_cx0, enc_cx1;
    logic [11:0] enc_take = '0;
    logic [5:0]  enc_busy = '0;

    int checks = 0;
    int errors = 0;

    logic [5:0] q [NL][$];
    bit  held = 0;
    bit  stall_m = 0;
    int  cur = 0;
    int  nxt = 0;
    bit  busy_force [NL];
    int  tail [NL];
    bit  rnd_busy = 0;

    always #2 clk = ~clk;

    bp_mq_alloc #(.DEPTH(DEPTH)) u_bp_mq_alloc (
        .clk(clk), .rst_n(rst_n),
        .pass_valid(pass_valid), .pass_cx(pass_cx), .pass_d(pass_d), .pass_ready(pass_ready),
        .plane_req(plane_req), .plane_gnt(plane_gnt), .act_eng(act_eng), .alloc_stall(alloc_stall),
        .enc_run(enc_run), .enc_two(enc_two), .enc_cx0(enc_cx0), .enc_d0(enc_d0),
        .enc_cx1(enc_cx1), .enc_d1(enc_d1), .enc_take(enc_take), .enc_busy(enc_busy)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int pair_avail(int l, int sz);
        if (sz == 0) return 0;
        if ((l % 3) != 1 && sz >= 2) return 2;
        return 1;
    endfunction

    task automatic drive_busy();
        for (int l = 0; l < NL; l++) begin
            enc_busy[l] = busy_force[l] || (tail[l] != 0);
        end
    endtask

    task automatic cycle();
        int  popn [NL];
        bit  pushv [NL];
        logic [5:0] pdat [NL];
        bit  fr [2];
        bit  gnt_e;
        @(negedge clk);
        for (int e = 0; e < 2; e++) begin
            fr[e] = 1;
            for (int p = 0; p < 3; p++) begin
                if (q[e*3+p].size() != 0 || enc_busy[e*3+p]) fr[e] = 0;
            end
        end
        gnt_e = plane_req && fr[nxt];
        chk("R6 grant", plane_gnt, gnt_e);
        chk("R5 act_eng", act_eng, cur);
        chk("R7 stall", alloc_stall, stall_m);
        for (int l = 0; l < NL; l++) begin
            pushv[l] = 0;
            pdat[l] = '0;
        end
        for (int p = 0; p < 3; p++) begin
            bit re;
            re = held && !plane_req && (q[cur*3+p].size() < DEPTH);
            chk((held && !plane_req) ? "R3 ready" : "R2 ready", pass_ready[p], re);
            if (pass_valid[p] && re) begin
                pushv[cur*3+p] = 1;
                pdat[cur*3+p] = {pass_cx[p*5 +: 5], pass_d[p]};
            end
        end
        for (int l = 0; l < NL; l++) begin
            int sz, av, tk;
            sz = q[l].size();
            av = pair_avail(l, sz);
            chk("R8 run", enc_run[l], sz != 0);
            if (sz != 0) chk("R4/R8 head", {enc_cx0[l*5 +: 5], enc_d0[l]}, q[l][0]);
            chk("R9 two", enc_two[l], av == 2);
            if (av == 2) chk("R9 second", {enc_cx1[l*5 +: 5], enc_d1[l]}, q[l][1]);
            tk = enc_take[2*l +: 2];
            if (tk == 3) tk = 2;
            popn[l] = (tk < av) ? tk : av;
        end
        @(posedge clk);
        for (int l = 0; l < NL; l++) begin
            for (int k = 0; k < popn[l]; k++) void'(q[l].pop_front());
            if (pushv[l]) q[l].push_back(pdat[l]);
            if (rnd_busy && popn[l] != 0) tail[l] = $urandom % 3;
            else if (tail[l] > 0) tail[l]--;
        end
        if (gnt_e) begin
            held = 1; stall_m = 0; cur = nxt; nxt = nxt ^ 1;
        end else if (plane_req) begin
            held = 0; stall_m = 1;
        end
        #1;
        if (gnt_e) plane_req = 1'b0;
        drive_busy();
    endtask

    task automatic rand_pairs(logic [2:0] vmask);
        pass_valid = vmask;
        pass_cx = 15'($urandom);
        pass_d = 3'($urandom);
    endtask

    initial begin
        void'($urandom(32'h5EED_0A11));
        for (int l = 0; l < NL; l++) begin
            busy_force[l] = 0;
            tail[l] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 ready", pass_ready, 0);
        chk("R1 gnt", plane_gnt, 0);
        chk("R1 stall", alloc_stall, 0);
        chk("R1 run", enc_run, 0);
        chk("R1 two", enc_two, 0);
        chk("R1 act", act_eng, 0);
        @(posedge clk); #1 rst_n = 1'b1;

        // R2: pairs offered before any grant are refused
        for (int i = 0; i < 4; i++) begin rand_pairs(3'b111); cycle(); end
        chk("R2 nothing stored", enc_run, 0);

        // first grant goes to engine 0 (R5, R6)
        pass_valid = '0; plane_req = 1'b1;
        cycle();
        chk("R5 first engine", act_eng, 0);

        // fill significance lane of engine 0 past its depth (R3)
        for (int i = 0; i < 20; i++) begin rand_pairs(3'b001); cycle(); end
        chk("R3 full lane refuses", pass_ready[0], 0);

        // second grant to engine 1 while engine 0 is loaded (R5)
        pass_valid = '0; plane_req = 1'b1;
        cycle();
        chk("R5 second engine", act_eng, 1);
        for (int i = 0; i < 3; i++) begin rand_pairs(3'b111); cycle(); end
        pass_valid = '0;

        // R10: take code 3 on refinement lane pops one; take on empty lane ignored
        enc_take = '0;
        enc_take[2*4 +: 2] = 2'd3;
        enc_take[2*1 +: 2] = 2'd2;
        cycle();
        enc_take = '0;
        cycle();
        chk("R10 ref lane clipped", enc_two[4], 0);
        chk("R10 empty lane untouched", enc_run[1], 0);

        // third request targets loaded engine 0: stall (R6, R7)
        busy_force[0] = 1; drive_busy();
        plane_req = 1'b1;
        for (int i = 0; i < 3; i++) cycle();
        chk("R7 stalled", alloc_stall, 1);
        // drain two per cycle (R9) while busy still held (R6)
        enc_take[1:0] = 2'd2;
        for (int i = 0; i < 10; i++) cycle();
        chk("R6 busy blocks grant", plane_gnt, 0);
        busy_force[0] = 0; drive_busy();
        cycle();
        chk("R5 third engine", act_eng, 0);
        enc_take = '0;

        // random phase
        rnd_busy = 1;
        for (int i = 0; i < 4000; i++) begin
            rand_pairs(3'($urandom));
            enc_take = 12'($urandom);
            if (!plane_req && held && ($urandom % 25) == 0) plane_req = 1'b1;
            cycle();
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule